// File: doc/BRIEF.md
# Predicate Mask Lookup Unit

This block answers one question for an instruction operand: which elements of a parallel operation are active. Software programs a small set of predication entries. Each entry names an operand register (by kind, integer or floating-point, and number) and the integer register whose contents supply the element mask. An entry also carries an invert flag and a zeroing flag.

A rebuild pulse expands the entries into two 32-slot tables, one per register kind. Lookups are then a direct index into these tables rather than a search. A lookup presents a kind bit and a register number. In the same cycle the block returns three things: whether the operand is predicated, the zeroing flag, and the XLEN-bit mask. Bit i of the mask governs element i.

The mask always comes from the integer register file, through a combinational read port, even when the operand is a floating-point register. It is complemented in full when the invert flag is set. An operand with no enabled slot gets an all-ones mask, so every element runs.

Top module: `pred_mask_lookup`

## Requirements
- R1: After reset, and until the first rebuild, every slot is disabled. Every lookup returns lk_en=0, lk_zero=0 and an all-ones lk_mask.
- R2: When cfg_we is high at a clock edge, cfg_data is stored into entry cfg_idx. The fields of cfg_data are: bits [4:0] operand register number, bit [5] kind (0 integer, 1 floating-point), bits [10:6] mask register number, bit [11] invert, bit [12] zeroing, bit [13] bank. A stored entry has no effect on lookups until the next rebuild.
- R3: When rebuild is high at a clock edge, all 64 slots are cleared. Each entry with bank 0 then enables the slot addressed by its kind and operand register. The new tables are visible from the following cycle. A rebuild uses the entry contents from before any write in the same cycle. Without a rebuild, the lookup outputs for fixed lookup inputs and register data do not change.
- R4: A lookup returns the enable and zeroing flag of the slot addressed by lk_type and lk_reg. lk_zero is never 1 when lk_en is 0.
- R5: For an enabled slot, ireg_addr carries the slot's mask register number, and lk_mask reflects ireg_data in the same cycle. This holds for floating-point slots too.
- R6: When the slot's invert flag is 1, lk_mask is the bitwise complement of ireg_data; otherwise lk_mask equals ireg_data.
- R7: A lookup of a disabled slot returns lk_en=0, lk_zero=0 and lk_mask with all XLEN bits set to 1.
- R8: An entry whose bank bit is 1 enables no slot on rebuild.
- R9: If several bank-0 entries share the same kind and operand register, the one with the highest entry index decides that slot.
- R10: After an entry's operand register is changed and a rebuild occurs, the slot it previously enabled reads as disabled, unless another entry names that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | 4 | Entry index to write |
| cfg_data | input | 14 | Entry contents (layout in R2) |
| rebuild | input | 1 | Expand entries into the slot tables |
| lk_type | input | 1 | Lookup register kind (0 integer, 1 floating-point) |
| lk_reg | input | 5 | Lookup register number |
| lk_en | output | 1 | Operand is predicated |
| lk_zero | output | 1 | Inactive elements are to be zeroed |
| lk_mask | output | 64 | Element mask, bit i for element i |
| ireg_addr | output | 5 | Integer register read address |
| ireg_data | input | 64 | Integer register read data (same cycle) |

## Verification
Several properties are checked on every cycle:
- the mask is either the register data or its exact complement whenever a slot is enabled;
- disabled slots give an all-ones mask;
- zeroing never appears without enable;
- nothing is enabled before the first rebuild;
- the outputs hold steady unless a rebuild, a new lookup or new register data intervenes.

Other behaviours depend on the history of writes and rebuilds, and only the bench scenarios can show them:
- which mask register is addressed;
- whether inversion matches the programmed flag;
- that bank-1 entries are skipped;
- that the highest duplicate entry wins;
- that a rebuild in the same cycle as a write sees the old entry;
- that stale slots disappear.

// File: rtl/pred_pkg.sv
package pred_pkg;
   typedef enum logic {
      KIND_INT = 1'b0,
      KIND_FP  = 1'b1
   } reg_kind_e;

   localparam int NUM_KINDS = 2;

   // extra one-bit fields per entry beyond the two register numbers and kind
   localparam int ENTRY_FLAG_BITS = 3;
endpackage

// File: rtl/pred_entry_store.sv
module pred_entry_store #(
   parameter int NUM_ENTRIES = 16,
   parameter int CFG_W       = 14,
   localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    we,
   input  logic [IDX_W-1:0]                        idx,
   input  logic [CFG_W-1:0]                        wdata,
   output logic [NUM_ENTRIES-1:0][CFG_W-1:0]       entries
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         entries <= '0;
      end else if (we) begin
         entries[idx] <= wdata;
      end
   end
endmodule

// File: rtl/pred_table_build.sv
module pred_table_build
   import pred_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int NUM_REGS    = 32,
   localparam int REG_AW     = $clog2(NUM_REGS),
   localparam int CFG_W      = 2 * REG_AW + 1 + ENTRY_FLAG_BITS
) (
   input  logic                                             clk,
   input  logic                                             rst_n,
   input  logic                                             rebuild,
   input  logic [NUM_ENTRIES-1:0][CFG_W-1:0]                entries,
   output logic [NUM_KINDS-1:0][NUM_REGS-1:0]               slot_en,
   output logic [NUM_KINDS-1:0][NUM_REGS-1:0]               slot_zero,
   output logic [NUM_KINDS-1:0][NUM_REGS-1:0]               slot_inv,
   output logic [NUM_KINDS-1:0][NUM_REGS-1:0][REG_AW-1:0]   slot_src
);
   localparam int KEY_LSB  = 0;
   localparam int KIND_BIT = REG_AW;
   localparam int SRC_LSB  = REG_AW + 1;
   localparam int INV_BIT  = 2 * REG_AW + 1;
   localparam int ZERO_BIT = 2 * REG_AW + 2;
   localparam int BANK_BIT = 2 * REG_AW + 3;

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      logic [NUM_REGS-1:0]             en_d, zero_d, inv_d;
      logic [NUM_REGS-1:0]             en_q, zero_q, inv_q;
      logic [NUM_REGS-1:0][REG_AW-1:0] src_d, src_q;

      // ascending entry order: a later entry overwrites an earlier one
      always_comb begin
         en_d   = '0;
         zero_d = '0;
         inv_d  = '0;
         src_d  = '0;
         for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (!entries[e][BANK_BIT] && (entries[e][KIND_BIT] == 1'(k))) begin
               en_d  [entries[e][KEY_LSB +: REG_AW]] = 1'b1;
               zero_d[entries[e][KEY_LSB +: REG_AW]] = entries[e][ZERO_BIT];
               inv_d [entries[e][KEY_LSB +: REG_AW]] = entries[e][INV_BIT];
               src_d [entries[e][KEY_LSB +: REG_AW]] = entries[e][SRC_LSB +: REG_AW];
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q   <= '0;
            zero_q <= '0;
            inv_q  <= '0;
            src_q  <= '0;
         end else if (rebuild) begin
            en_q   <= en_d;
            zero_q <= zero_d;
            inv_q  <= inv_d;
            src_q  <= src_d;
         end
      end

      assign slot_en[k]   = en_q;
      assign slot_zero[k] = zero_q;
      assign slot_inv[k]  = inv_q;
      assign slot_src[k]  = src_q;
   end
endmodule

// File: rtl/pred_mask_select.sv
module pred_mask_select
   import pred_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int NUM_REGS = 32,
   localparam int REG_AW  = $clog2(NUM_REGS)
) (
   input  logic                                            lk_type,
   input  logic [REG_AW-1:0]                               lk_reg,
   input  logic [NUM_KINDS-1:0][NUM_REGS-1:0]              slot_en,
   input  logic [NUM_KINDS-1:0][NUM_REGS-1:0]              slot_zero,
   input  logic [NUM_KINDS-1:0][NUM_REGS-1:0]              slot_inv,
   input  logic [NUM_KINDS-1:0][NUM_REGS-1:0][REG_AW-1:0]  slot_src,
   input  logic [XLEN-1:0]                                 ireg_data,
   output logic [REG_AW-1:0]                               ireg_addr,
   output logic                                            lk_en,
   output logic                                            lk_zero,
   output logic [XLEN-1:0]                                 lk_mask
);
   logic hit_en, hit_inv, hit_zero;

   assign hit_en   = slot_en  [lk_type][lk_reg];
   assign hit_inv  = slot_inv [lk_type][lk_reg];
   assign hit_zero = slot_zero[lk_type][lk_reg];

   assign ireg_addr = hit_en ? slot_src[lk_type][lk_reg] : '0;
   assign lk_en     = hit_en;
   assign lk_zero   = hit_en & hit_zero;

   always_comb begin
      if (!hit_en) begin
         lk_mask = '1;
      end else begin
         lk_mask = ireg_data ^ {XLEN{hit_inv}};
      end
   end
endmodule

// File: rtl/pred_mask_lookup.sv
module pred_mask_lookup
   import pred_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int NUM_REGS    = 32,
   parameter int NUM_ENTRIES = 16,
   localparam int REG_AW     = $clog2(NUM_REGS),
   localparam int IDX_W      = $clog2(NUM_ENTRIES),
   localparam int CFG_W      = 2 * REG_AW + 1 + ENTRY_FLAG_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [CFG_W-1:0]   cfg_data,
   input  logic               rebuild,
   input  logic               lk_type,
   input  logic [REG_AW-1:0]  lk_reg,
   output logic               lk_en,
   output logic               lk_zero,
   output logic [XLEN-1:0]    lk_mask,
   output logic [REG_AW-1:0]  ireg_addr,
   input  logic [XLEN-1:0]    ireg_data
);
   if (NUM_REGS != (1 << REG_AW)) begin : g_bad_regs
      $error("NUM_REGS must be a power of two");
   end
   if (NUM_ENTRIES < 2 || NUM_ENTRIES != (1 << IDX_W)) begin : g_bad_entries
      $error("NUM_ENTRIES must be a power of two, at least 2");
   end
   if (XLEN < 1) begin : g_bad_xlen
      $error("XLEN must be positive");
   end

   logic [NUM_ENTRIES-1:0][CFG_W-1:0]              entries;
   logic [NUM_KINDS-1:0][NUM_REGS-1:0]             slot_en, slot_zero, slot_inv;
   logic [NUM_KINDS-1:0][NUM_REGS-1:0][REG_AW-1:0] slot_src;

   pred_entry_store #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .CFG_W       (CFG_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .idx     (cfg_idx),
      .wdata   (cfg_data),
      .entries (entries)
   );

   pred_table_build #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .NUM_REGS    (NUM_REGS)
   ) u_build (
      .clk       (clk),
      .rst_n     (rst_n),
      .rebuild   (rebuild),
      .entries   (entries),
      .slot_en   (slot_en),
      .slot_zero (slot_zero),
      .slot_inv  (slot_inv),
      .slot_src  (slot_src)
   );

   pred_mask_select #(
      .XLEN     (XLEN),
      .NUM_REGS (NUM_REGS)
   ) u_select (
      .lk_type   (lk_type),
      .lk_reg    (lk_reg),
      .slot_en   (slot_en),
      .slot_zero (slot_zero),
      .slot_inv  (slot_inv),
      .slot_src  (slot_src),
      .ireg_data (ireg_data),
      .ireg_addr (ireg_addr),
      .lk_en     (lk_en),
      .lk_zero   (lk_zero),
      .lk_mask   (lk_mask)
   );
endmodule

// File: rtl/pred_mask_lookup_chk.sv
module pred_mask_lookup_chk #(
   parameter int XLEN     = 64,
   parameter int REG_AW   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rebuild,
   input logic              lk_type,
   input logic [REG_AW-1:0] lk_reg,
   input logic              lk_en,
   input logic              lk_zero,
   input logic [XLEN-1:0]   lk_mask,
   input logic [XLEN-1:0]   ireg_data
);
   logic seen_rebuild;

   always_ff @(posedge clk) begin
      if (!rst_n) seen_rebuild <= 1'b0;
      else if (rebuild) seen_rebuild <= 1'b1;
   end

   assert_clear_before_rebuild_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_rebuild |-> !lk_en);

   assert_hold_without_rebuild_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rebuild) && $stable(lk_type) && $stable(lk_reg) && $stable(ireg_data))
      |-> ($stable(lk_en) && $stable(lk_zero) && $stable(lk_mask)));

   assert_zero_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lk_zero |-> lk_en);

   assert_mask_from_register_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_en |-> ((lk_mask == ireg_data) || (lk_mask == ~ireg_data)));

   assert_disabled_all_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_en |-> (&lk_mask));
endmodule

bind pred_mask_lookup pred_mask_lookup_chk #(
   .XLEN   (XLEN),
   .REG_AW (REG_AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rebuild   (rebuild),
   .lk_type   (lk_type),
   .lk_reg    (lk_reg),
   .lk_en     (lk_en),
   .lk_zero   (lk_zero),
   .lk_mask   (lk_mask),
   .ireg_data (ireg_data)
);

// File: tb/pred_mask_lookup_bench.sv
module pred_mask_lookup_bench;
   localparam int XLEN = 64;
   localparam int NR   = 32;
   localparam int NE   = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [3:0]      cfg_idx = '0;
   logic [13:0]     cfg_data = '0;
   logic            rebuild = 1'b0;
   logic            lk_type = 1'b0;
   logic [4:0]      lk_reg = '0;
   logic            lk_en, lk_zero;
   logic [XLEN-1:0] lk_mask;
   logic [4:0]      ireg_addr;
   logic [XLEN-1:0] ireg_data;

   logic [XLEN-1:0] rf [NR];
   assign ireg_data = rf[ireg_addr];

   always #4 clk = ~clk;

   pred_mask_lookup u_pred_mask_lookup (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .rebuild(rebuild), .lk_type(lk_type),
      .lk_reg(lk_reg), .lk_en(lk_en), .lk_zero(lk_zero),
      .lk_mask(lk_mask), .ireg_addr(ireg_addr), .ireg_data(ireg_data)
   );

   // behavioural reference state
   int  m_kind[NE], m_key[NE], m_src[NE], m_inv[NE], m_zero[NE], m_bank[NE];
   bit  t_en[2][NR], t_zero[2][NR], t_inv[2][NR];
   int  t_src[2][NR];
   int  checks = 0, errors = 0;
   bit  done = 1'b0;

   function automatic logic [13:0] mk(int kind, int key, int src, int inv, int zero, int bank);
      mk = {1'(bank), 1'(zero), 1'(inv), 5'(src), 1'(kind), 5'(key)};
   endfunction

   task automatic model_edge();
      if (!rst_n) begin
         foreach (t_en[k, r]) begin t_en[k][r] = 0; t_zero[k][r] = 0; t_inv[k][r] = 0; t_src[k][r] = 0; end
         for (int e = 0; e < NE; e++) begin
            m_kind[e] = 0; m_key[e] = 0; m_src[e] = 0; m_inv[e] = 0; m_zero[e] = 0; m_bank[e] = 0;
         end
      end else begin
         if (rebuild) begin
            foreach (t_en[k, r]) begin t_en[k][r] = 0; t_zero[k][r] = 0; t_inv[k][r] = 0; t_src[k][r] = 0; end
            for (int e = 0; e < NE; e++) begin
               if (m_bank[e] == 0) begin
                  t_en[m_kind[e]][m_key[e]]   = 1;
                  t_zero[m_kind[e]][m_key[e]] = m_zero[e] != 0;
                  t_inv[m_kind[e]][m_key[e]]  = m_inv[e] != 0;
                  t_src[m_kind[e]][m_key[e]]  = m_src[e];
               end
            end
         end
         if (cfg_we) begin
            m_key[cfg_idx]  = int'(cfg_data[4:0]);
            m_kind[cfg_idx] = int'(cfg_data[5]);
            m_src[cfg_idx]  = int'(cfg_data[10:6]);
            m_inv[cfg_idx]  = int'(cfg_data[11]);
            m_zero[cfg_idx] = int'(cfg_data[12]);
            m_bank[cfg_idx] = int'(cfg_data[13]);
         end
      end
   endtask

   task automatic compare(input string tag);
      logic            e_en, e_zero;
      logic [XLEN-1:0] e_mask;
      e_en = t_en[lk_type][lk_reg];
      if (e_en) begin
         e_zero = t_zero[lk_type][lk_reg];
         e_mask = rf[t_src[lk_type][lk_reg]];
         if (t_inv[lk_type][lk_reg]) e_mask = ~e_mask;
      end else begin
         e_zero = 1'b0;
         e_mask = '1;
      end
      checks++;
      if (lk_en !== e_en || lk_zero !== e_zero || lk_mask !== e_mask) begin
         errors++;
         $display("FAIL %s kind=%0d reg=%0d actual en=%0b zero=%0b mask=%h expected en=%0b zero=%0b mask=%h",
                  tag, lk_type, lk_reg, lk_en, lk_zero, lk_mask, e_en, e_zero, e_mask);
      end
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic wr(input int idx, input logic [13:0] d, input bit with_rebuild, input string tag);
      cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_data = d; rebuild = with_rebuild;
      step(tag);
      cfg_we = 1'b0; rebuild = 1'b0;
   endtask

   task automatic rb(input string tag);
      rebuild = 1'b1;
      step(tag);
      rebuild = 1'b0;
   endtask

   task automatic look(input int kind, input int r, input string tag);
      lk_type = 1'(kind); lk_reg = 5'(r);
      step(tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NR; i++)
         rf[i] = {32'(i * 32'h0101_0101) ^ 32'hA5C3_0F00, 32'((i + 7) * 32'h0011_2233)};
      // reset
      step("R1"); step("R1");
      rst_n = 1'b1;
      for (int r = 0; r < NR; r += 5) begin look(0, r, "R1"); look(1, r, "R1"); end

      // program entries; no effect before rebuild
      wr(0, mk(0, 3, 7, 0, 0, 0), 0, "R2");
      wr(1, mk(1, 3, 9, 1, 1, 0), 0, "R2");
      wr(2, mk(0, 10, 0, 0, 1, 0), 0, "R2");
      wr(3, mk(0, 12, 5, 0, 0, 1), 0, "R8");
      look(0, 3, "R2"); look(1, 3, "R2");
      rb("R3");
      look(0, 3, "R5");
      look(1, 3, "R6");
      look(0, 10, "R4");
      look(0, 12, "R8");
      look(0, 5, "R7");
      look(1, 12, "R7");
      // same-cycle register change is reflected
      lk_type = 1'b1; lk_reg = 5'd3;
      rf[9] = 64'h0000_0000_FFFF_0001;
      step("R5");
      rf[9] = 64'hFFFF_FFFF_FFFF_FFFF;
      step("R6");

      // duplicate key: highest index decides
      wr(5, mk(0, 20, 2, 0, 0, 0), 0, "R9");
      wr(9, mk(0, 20, 4, 1, 1, 0), 0, "R9");
      rb("R9");
      look(0, 20, "R9");
      look(0, 0, "R9");

      // write together with rebuild: rebuild sees the old entry
      wr(0, mk(0, 4, 11, 1, 0, 0), 1, "R3");
      look(0, 3, "R3"); look(0, 4, "R3");
      rb("R10");
      look(0, 3, "R10"); look(0, 4, "R10");

      // full sweep with changing register data
      for (int pass = 0; pass < 2; pass++) begin
         for (int k = 0; k < 2; k++)
            for (int r = 0; r < NR; r++) begin
               rf[(r * 3 + pass) % NR] = ~rf[(r * 3 + pass) % NR];
               look(k, r, "R4");
            end
         wr(3, mk(0, 12, 5, 1, 1, 0), 0, "R8");
         rb("R8");
         look(0, 12, "R8");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule